// File: doc/BRIEF.md
# Cross-Power Spectrum Accumulator

This block sits behind a pair of FFT engines and integrates their outputs into averaged spectra. Each input beat carries one complex bin from input A and the bin with the same index from input B, plus a marker that flags bin zero of a new spectrum. For every bin the block forms |A|², |B|² and the complex product A·conj(B). It sums these into per-bin accumulators held in inferred RAM over a programmable number of spectra.

When the last bin of the last spectrum has been summed, the block stops taking input. It waits for its two-stage read-modify-write pipeline to empty, then streams the finished spectra out one bin at a time under valid/ready flow control. The first spectrum of the next integration overwrites the accumulators instead of adding to them, so no separate clearing pass is needed.

The controller is a four-state machine. ACCUMULATE takes beats. It moves to DRAIN on the final beat of an integration. DRAIN moves to FETCH once the pipeline is empty. FETCH issues the RAM read for the current dump bin and always moves to PRESENT. PRESENT holds the bin on the output. On a handshake it moves back to FETCH for the next bin, or to ACCUMULATE after the last bin.

Top module: `xps_accum`

## Requirements
- R1: After reset `out_valid` and `frame_err` are 0 and `in_ready` is 1.
- R2: `out_pwr_a` equals the sum over the integration of re_a²+im_a² for that bin, and `out_pwr_b` is the same for B. Both are unsigned 48-bit values.
- R3: `out_xc_re` equals the sum of re_a·re_b+im_a·im_b. `out_xc_im` equals the sum of im_a·re_b−re_a·im_b. Both are 48-bit two's complement values.
- R4: One integration is `cfg_nspec` spectra of NCH beats each. A `cfg_nspec` of 0 behaves as 1.
- R5: Results of one integration never carry into the next. The first spectrum loads the accumulators.
- R6: `in_ready` is 0 from the final beat of an integration until the handshake of the last dumped bin. Bins are dumped in index order 0..NCH−1 on `out_ch`. `in_ready` is 1 again in the cycle after that last handshake.
- R7: While `out_valid` is 1 and `out_ready` is 0, every output holds its value.
- R8: Beats that hit the same bin in consecutive cycles are all summed, including the wrap from one spectrum to the next.
- R9: A beat with `in_sos`=1 at a nonzero expected bin sets `frame_err`, which stays 1 until reset. That beat becomes bin 0 of the first spectrum of a fresh integration.
- R10: A beat with `in_sos`=0 while the expected bin is 0 is dropped. It changes no accumulator, does not advance the bin count and does not set `frame_err`.
- R11: Inputs with zero imaginary parts need no special handling. They give `out_xc_im`=0 and powers of re² alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nspec | input | CNT_W | Spectra per integration, held stable during an integration |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts input beats |
| in_sos | input | 1 | Beat is bin 0 of a spectrum |
| a_re | input | 18 | Input A real part, signed |
| a_im | input | 18 | Input A imaginary part, signed |
| b_re | input | 18 | Input B real part, signed |
| b_im | input | 18 | Input B imaginary part, signed |
| out_valid | output | 1 | Dumped bin present |
| out_ready | input | 1 | Consumer takes the dumped bin |
| out_ch | output | CH_W | Bin index of the dumped result |
| out_pwr_a | output | 48 | Accumulated self-power of A |
| out_pwr_b | output | 48 | Accumulated self-power of B |
| out_xc_re | output | 48 | Accumulated cross-power, real part |
| out_xc_im | output | 48 | Accumulated cross-power, imaginary part |
| frame_err | output | 1 | Sticky misplaced start-of-spectrum flag |

## Verification
The bench drives full-scale negative and positive bins, real-only bins and zero bins, so that a wrong sign extension or a swapped conjugate term shows up as a wrong sum or a wrong sign on the imaginary cross term. A design that kept old contents across integrations would report inflated sums in the second run. A single-bin instance fed back-to-back beats exposes a missing read-after-write bypass, which would lose all but one product in each pair of consecutive beats. A misplaced marker and a marker-less beat at bin 0 are both sent. A design that mishandled them would either keep the partial spectrum, or shift every bin and raise the error flag. The consumer is stalled in the middle of the dump, and a design that let the data move would fail the hold check.

// File: rtl/xps_pkg.sv
package xps_pkg;

    localparam int SMP_W = 18;
    localparam int ACC_W = 48;
    localparam int LANES = 4;

    // lane indices inside one accumulator word
    localparam int L_PA = 0;
    localparam int L_PB = 1;
    localparam int L_XR = 2;
    localparam int L_XI = 3;

    typedef logic [LANES-1:0][ACC_W-1:0] acc_t;

    typedef enum logic [1:0] {
        ST_ACCUM,
        ST_DRAIN,
        ST_FETCH,
        ST_PRESENT
    } xps_state_e;

endpackage

// File: rtl/xps_power.sv
module xps_power
    import xps_pkg::*;
(
    input  logic signed [SMP_W-1:0] a_re,
    input  logic signed [SMP_W-1:0] a_im,
    input  logic signed [SMP_W-1:0] b_re,
    input  logic signed [SMP_W-1:0] b_im,
    output acc_t                    prod
);

    localparam int PW = 2 * SMP_W;

    logic signed [PW-1:0] m_aa_r, m_aa_i, m_bb_r, m_bb_i;
    logic signed [PW-1:0] m_rr, m_ii, m_ir, m_ri;

    function automatic logic [ACC_W-1:0] ext(input logic signed [PW-1:0] v);
        return ACC_W'(v);
    endfunction

    always_comb begin
        m_aa_r = PW'(a_re) * PW'(a_re);
        m_aa_i = PW'(a_im) * PW'(a_im);
        m_bb_r = PW'(b_re) * PW'(b_re);
        m_bb_i = PW'(b_im) * PW'(b_im);
        m_rr   = PW'(a_re) * PW'(b_re);
        m_ii   = PW'(a_im) * PW'(b_im);
        m_ir   = PW'(a_im) * PW'(b_re);
        m_ri   = PW'(a_re) * PW'(b_im);

        prod[L_PA] = ext(m_aa_r) + ext(m_aa_i);
        prod[L_PB] = ext(m_bb_r) + ext(m_bb_i);
        // A times conjugate of B
        prod[L_XR] = ext(m_rr) + ext(m_ii);
        prod[L_XI] = ext(m_ir) - ext(m_ri);
    end

endmodule

// File: rtl/xps_acc_mem.sv
module xps_acc_mem
    import xps_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output acc_t          rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  acc_t          wr_data
);

    acc_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= store[rd_addr];
        end
    end

endmodule

// File: rtl/xps_ctrl.sv
module xps_ctrl
    import xps_pkg::*;
#(
    parameter int NCH   = 512,
    parameter int CNT_W = 16,
    parameter int CH_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_nspec,
    input  logic             in_valid,
    input  logic             in_sos,
    input  logic             out_ready,
    input  logic             pipe_busy,
    output logic             in_ready,
    output logic             beat_ok,
    output logic [CH_W-1:0]  beat_ch,
    output logic             beat_first,
    output logic             rd_en,
    output logic [CH_W-1:0]  rd_addr,
    output logic             out_valid,
    output logic [CH_W-1:0]  dump_ch,
    output logic             frame_err
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

    xps_state_e       state_q, state_d;
    logic [CH_W-1:0]  ch_q, dump_q;
    logic [CNT_W-1:0] spec_q, eff_spec;
    logic             err_q;
    logic             take, mid_sos, last_ch, last_spec, end_int, shake;

    // beat classification
    always_comb begin
        take       = in_valid && (state_q == ST_ACCUM);
        mid_sos    = take && in_sos && (ch_q != '0);
        beat_ok    = take && (in_sos || (ch_q != '0));
        beat_ch    = in_sos ? '0 : ch_q;
        eff_spec   = mid_sos ? '0 : spec_q;
        beat_first = (eff_spec == '0);
        last_ch    = (beat_ch == LAST_CH);
        last_spec  = ({1'b0, eff_spec} + (CNT_W+1)'(1)) >= {1'b0, cfg_nspec};
        end_int    = beat_ok && last_ch && last_spec;
        shake      = (state_q == ST_PRESENT) && out_ready;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCUM:   if (end_int)    state_d = ST_DRAIN;
            ST_DRAIN:   if (!pipe_busy) state_d = ST_FETCH;
            ST_FETCH:                   state_d = ST_PRESENT;
            ST_PRESENT: if (shake)      state_d = (dump_q == LAST_CH) ? ST_ACCUM : ST_FETCH;
            default:                    state_d = ST_ACCUM;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACCUM;
        end else begin
            state_q <= state_d;
        end
    end

    // counters and sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q   <= '0;
            spec_q <= '0;
            dump_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (beat_ok) begin
                ch_q <= last_ch ? '0 : beat_ch + CH_W'(1);
                if (last_ch) begin
                    spec_q <= last_spec ? '0 : eff_spec + CNT_W'(1);
                end else begin
                    spec_q <= eff_spec;
                end
            end
            if (shake) begin
                dump_q <= (dump_q == LAST_CH) ? '0 : dump_q + CH_W'(1);
            end
            err_q <= err_q | mid_sos;
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        rd_en     = beat_ok;
        rd_addr   = beat_ch;
        unique case (state_q)
            ST_ACCUM:   in_ready = 1'b1;
            ST_DRAIN:   rd_en    = 1'b0;
            ST_FETCH: begin
                rd_en   = 1'b1;
                rd_addr = dump_q;
            end
            ST_PRESENT: out_valid = 1'b1;
            default:    rd_en     = 1'b0;
        endcase
        dump_ch   = dump_q;
        frame_err = err_q;
    end

endmodule

// File: rtl/xps_accum.sv
module xps_accum
    import xps_pkg::*;
#(
    parameter int  NCH   = 512,
    parameter int  CNT_W = 16,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        cfg_nspec,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_sos,
    input  logic signed [SMP_W-1:0] a_re,
    input  logic signed [SMP_W-1:0] a_im,
    input  logic signed [SMP_W-1:0] b_re,
    input  logic signed [SMP_W-1:0] b_im,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [CH_W-1:0]         out_ch,
    output logic [ACC_W-1:0]        out_pwr_a,
    output logic [ACC_W-1:0]        out_pwr_b,
    output logic [ACC_W-1:0]        out_xc_re,
    output logic [ACC_W-1:0]        out_xc_im,
    output logic                    frame_err
);

    logic            beat_ok, beat_first, rd_en;
    logic [CH_W-1:0] beat_ch, rd_addr, dump_ch;
    acc_t            prod, rd_q, base, nsum;

    // stage-1 registers
    logic            s1_valid, s1_first, s1_byp;
    logic [CH_W-1:0] s1_ch;
    acc_t            s1_prod, s1_bval;

    xps_ctrl #(
        .NCH   (NCH),
        .CNT_W (CNT_W),
        .CH_W  (CH_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_nspec  (cfg_nspec),
        .in_valid   (in_valid),
        .in_sos     (in_sos),
        .out_ready  (out_ready),
        .pipe_busy  (s1_valid),
        .in_ready   (in_ready),
        .beat_ok    (beat_ok),
        .beat_ch    (beat_ch),
        .beat_first (beat_first),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .out_valid  (out_valid),
        .dump_ch    (dump_ch),
        .frame_err  (frame_err)
    );

    xps_power u_power (
        .a_re (a_re),
        .a_im (a_im),
        .b_re (b_re),
        .b_im (b_im),
        .prod (prod)
    );

    xps_acc_mem #(
        .DEPTH (NCH),
        .AW    (CH_W)
    ) u_mem (
        .clk     (clk),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_q),
        .wr_en   (s1_valid),
        .wr_addr (s1_ch),
        .wr_data (nsum)
    );

    // stage 2: combine stored (or bypassed) sum with product
    always_comb begin
        base = s1_byp ? s1_bval : rd_q;
        for (int l = 0; l < LANES; l++) begin
            nsum[l] = s1_first ? s1_prod[l] : base[l] + s1_prod[l];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= beat_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (beat_ok) begin
            s1_ch    <= beat_ch;
            s1_first <= beat_first;
            s1_prod  <= prod;
            // the read issued now misses the write landing this cycle
            s1_byp   <= s1_valid && (s1_ch == beat_ch);
            s1_bval  <= nsum;
        end
    end

    assign out_ch    = dump_ch;
    assign out_pwr_a = rd_q[L_PA];
    assign out_pwr_b = rd_q[L_PB];
    assign out_xc_re = rd_q[L_XR];
    assign out_xc_im = rd_q[L_XI];

endmodule

// File: rtl/xps_accum_chk.sv
module xps_accum_chk
    import xps_pkg::*;
#(
    parameter int  NCH  = 512,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [CH_W-1:0]  out_ch,
    input logic [ACC_W-1:0] out_pwr_a,
    input logic [ACC_W-1:0] out_pwr_b,
    input logic [ACC_W-1:0] out_xc_re,
    input logic [ACC_W-1:0] out_xc_im,
    input logic             frame_err
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

    a_r6_dump_blocks_intake: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r6_reopen_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_ch == LAST_CH) |=> (in_ready && !out_valid));

    a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_ch) && $stable(out_pwr_a)
            && $stable(out_pwr_b) && $stable(out_xc_re) && $stable(out_xc_im)));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

endmodule

bind xps_accum xps_accum_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/test_xps_accum.sv
`timescale 1ns/1ps
module test_xps_accum;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [15:0] cfg_nspec = 16'd1;
    logic sel_one = 1'b0, drv_valid = 1'b0, drv_sos = 1'b0;
    logic signed [17:0] d_are = '0, d_aim = '0, d_bre = '0, d_bim = '0;
    logic m_rdy = 1'b0, o_rdy = 1'b0;

    logic m_in_ready, m_valid_o, m_err;
    logic [1:0] m_ch;
    logic [47:0] m_pa, m_pb, m_xr, m_xi;
    logic o_in_ready, o_valid_o, o_err;
    logic [0:0] o_ch;
    logic [47:0] o_pa, o_pb, o_xr, o_xi;

    xps_accum #(.NCH(4), .CNT_W(16)) i_xps_accum (
        .clk(clk), .rst_n(rst_n), .cfg_nspec(cfg_nspec),
        .in_valid(drv_valid & ~sel_one), .in_ready(m_in_ready), .in_sos(drv_sos),
        .a_re(d_are), .a_im(d_aim), .b_re(d_bre), .b_im(d_bim),
        .out_valid(m_valid_o), .out_ready(m_rdy), .out_ch(m_ch),
        .out_pwr_a(m_pa), .out_pwr_b(m_pb), .out_xc_re(m_xr), .out_xc_im(m_xi),
        .frame_err(m_err));

    xps_accum #(.NCH(1), .CNT_W(16)) i_one (
        .clk(clk), .rst_n(rst_n), .cfg_nspec(cfg_nspec),
        .in_valid(drv_valid & sel_one), .in_ready(o_in_ready), .in_sos(drv_sos),
        .a_re(d_are), .a_im(d_aim), .b_re(d_bre), .b_im(d_bim),
        .out_valid(o_valid_o), .out_ready(o_rdy), .out_ch(o_ch),
        .out_pwr_a(o_pa), .out_pwr_b(o_pb), .out_xc_re(o_xr), .out_xc_im(o_xi),
        .frame_err(o_err));

    // rows: a_re, a_im, b_re, b_im ; rows with index 3 mod 4 are real-only
    localparam logic signed [17:0] VEC [16][4] = '{
        '{18'sd100,    -18'sd50,    18'sd30,     18'sd7},
        '{18'sh20000,  18'sh20000,  18'sd131071, 18'sh20000},
        '{18'sd0,      18'sd0,      18'sd0,      18'sd0},
        '{18'sd1234,   18'sd0,      -18'sd999,   18'sd0},
        '{-18'sd7,     18'sd3,      18'sd11,     -18'sd13},
        '{18'sd131071, 18'sd131071, 18'sd131071, 18'sd131071},
        '{18'sd500,    -18'sd600,   -18'sd700,   18'sd800},
        '{-18'sd40000, 18'sd0,      -18'sd50000, 18'sd0},
        '{18'sd1,      18'sd2,      18'sd3,      18'sd4},
        '{-18'sd100000, 18'sd20000, 18'sd30000,  -18'sd90000},
        '{18'sd65536,  -18'sd65536, -18'sd65536, 18'sd65536},
        '{18'sd77,     18'sd0,      18'sd88,     18'sd0},
        '{18'sd9,      18'sd9,      -18'sd9,     18'sd9},
        '{18'sd25000,  -18'sd35000, 18'sd45000,  18'sd55000},
        '{-18'sd1,     18'sd1,      -18'sd1,     -18'sd1},
        '{18'sd4095,   18'sd0,      18'sd8191,   18'sd0}
    };

    int checks = 0, fails = 0;
    bit done = 1'b0;
    longint ex_pa [4], ex_pb [4], ex_xr [4], ex_xi [4];

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clr();
        for (int c = 0; c < 4; c++) begin
            ex_pa[c] = 0; ex_pb[c] = 0; ex_xr[c] = 0; ex_xi[c] = 0;
        end
    endtask

    task automatic model_add(input int c, input int r);
        longint ar, ai, br, bi;
        ar = VEC[r][0]; ai = VEC[r][1]; br = VEC[r][2]; bi = VEC[r][3];
        ex_pa[c] += ar * ar + ai * ai;
        ex_pb[c] += br * br + bi * bi;
        ex_xr[c] += ar * br + ai * bi;
        ex_xi[c] += ai * br - ar * bi;
    endtask

    // call at a falling edge; leaves valid high for back-to-back use
    task automatic beat(input bit one, input bit sos, input int r);
        while (!(one ? o_in_ready : m_in_ready)) @(negedge clk);
        sel_one = one; drv_sos = sos; drv_valid = 1'b1;
        d_are = VEC[r][0]; d_aim = VEC[r][1]; d_bre = VEC[r][2]; d_bim = VEC[r][3];
        @(negedge clk);
    endtask

    task automatic idle();
        drv_valid = 1'b0;
        drv_sos = 1'b0;
    endtask

    task automatic collect(input bit one, input string tg);
        int n;
        longint snap;
        n = one ? 1 : 4;
        for (int c = 0; c < n; c++) begin
            while (!(one ? o_valid_o : m_valid_o)) @(negedge clk);
            if (!one) begin
                chk({tg, " R6 intake closed during dump"}, longint'(m_in_ready), 0);
                if (c == 1) begin
                    snap = longint'(m_pa);
                    repeat (2) @(negedge clk);
                    chk({tg, " R7 valid held under stall"}, longint'(m_valid_o), 1);
                    chk({tg, " R7 data held under stall"}, longint'(m_pa), snap);
                end
            end
            chk({tg, " R6 bin order"}, one ? longint'(o_ch) : longint'(m_ch), c);
            chk({tg, " R2 self power A"}, one ? longint'(o_pa) : longint'(m_pa), ex_pa[c]);
            chk({tg, " R2 self power B"}, one ? longint'(o_pb) : longint'(m_pb), ex_pb[c]);
            chk({tg, (c == 3) ? " R11 cross real" : " R3 cross real"},
                one ? longint'($signed(o_xr)) : longint'($signed(m_xr)), ex_xr[c]);
            chk({tg, (c == 3) ? " R11 cross imag" : " R3 cross imag"},
                one ? longint'($signed(o_xi)) : longint'($signed(m_xi)), ex_xi[c]);
            if (one) o_rdy = 1'b1; else m_rdy = 1'b1;
            @(negedge clk);
            o_rdy = 1'b0; m_rdy = 1'b0;
        end
        if (!one) chk({tg, " R6 intake reopens"}, longint'(m_in_ready), 1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid after reset", longint'(m_valid_o), 0);
        chk("R1 in_ready after reset", longint'(m_in_ready), 1);
        chk("R1 frame_err after reset", longint'(m_err), 0);
        chk("R1 single-bin out_valid after reset", longint'(o_valid_o), 0);

        // vector table: three spectra, real-only bin 3 (R4, R2, R3, R11)
        cfg_nspec = 16'd3;
        model_clr();
        for (int i = 0; i < 12; i++) begin
            beat(1'b0, (i % 4) == 0, i);
            model_add(i % 4, i);
        end
        idle();
        collect(1'b0, "int3");

        // R5: next integration of one spectrum must not see old sums
        cfg_nspec = 16'd1;
        model_clr();
        for (int i = 12; i < 16; i++) begin
            beat(1'b0, (i % 4) == 0, i);
            model_add(i % 4, i);
        end
        idle();
        collect(1'b0, "R5 reload");

        // R10: marker-less beat at bin 0 is dropped
        model_clr();
        beat(1'b0, 1'b0, 5);
        for (int i = 0; i < 4; i++) begin
            beat(1'b0, i == 0, i);
            model_add(i, i);
        end
        idle();
        chk("R10 no error from dropped beat", longint'(m_err), 0);
        collect(1'b0, "R10 drop");

        // R9: misplaced marker restarts the integration
        model_clr();
        beat(1'b0, 1'b1, 4);
        beat(1'b0, 1'b0, 5);
        for (int i = 8; i < 12; i++) begin
            beat(1'b0, i == 8, i);
            model_add(i - 8, i);
        end
        idle();
        chk("R9 error raised", longint'(m_err), 1);
        collect(1'b0, "R9 restart");
        chk("R9 error sticky after dump", longint'(m_err), 1);

        // R8: single bin, back-to-back beats across spectrum wrap
        cfg_nspec = 16'd4;
        model_clr();
        for (int i = 0; i < 4; i++) begin
            beat(1'b1, 1'b1, i);
            model_add(0, i);
        end
        idle();
        collect(1'b1, "R8 back-to-back");

        // R4: count of zero acts as one spectrum
        cfg_nspec = 16'd0;
        model_clr();
        beat(1'b1, 1'b1, 13);
        model_add(0, 13);
        idle();
        collect(1'b1, "R4 zero count");
        chk("R9 no error on single-bin stream", longint'(o_err), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule